// File: doc/BRIEF.md
# DRAM Bank Activation Timing Guard

This block sits on the command side of a memory controller for an eight-bank DDR2-class device. Each cycle it decodes the command on the active-low select and strobe lines, together with a 3-bit bank number and an all-banks qualifier. It then raises a single-cycle `cmd_ok` flag that says whether that command may be issued in the current cycle. To make that decision it keeps, for every bank, an open/closed bit and two saturating elapsed-cycle counters. It also keeps a short history of recent activates that covers the whole device.

The timing limits are clock counts supplied on configuration inputs. Each one is the nanosecond figure divided by the clock period and rounded up. A refused command leaves all bank state as it was. It also sets a sticky violation flag, which keeps the bank and the command code of the first refusal until reset. The block does not handle refresh, mode-register programming, data movement or the physical interface.

Top module: `dram_act_guard`

## Requirements
- R1: Command decode, with `cs_n` low: `ras_n,cas_n,we_n` = 0,1,1 is activate, 1,0,1 is read, 1,0,0 is write, and 0,1,0 is precharge. A precharge with `all_banks` high is precharge-all. Any other pattern, and any cycle with `cs_n` high, is unguarded, and `cmd_ok` is 1 for it.
- R2: Synchronous reset closes every bank, marks every counter as expired and clears the violation flag. An activate to any bank is legal in the first cycle after reset.
- R3: A read or write is legal only to an open bank. An activate is legal only to a closed bank. An accepted activate opens its bank.
- R4: An activate to a bank needs at least `t_rc` cycles since the previous activate to that same bank, and at least `t_rrd` cycles since the previous activate to any bank. A command k cycles after another sees an elapsed count of k.
- R5: A precharge to an open bank needs at least `t_ras` cycles since that bank was activated. A precharge to a closed bank is legal. A precharge-all is legal only if every open bank meets `t_ras`.
- R6: At most four activates may be accepted in any rolling window of `t_faw` cycles. A fifth activate is legal only once the fourth most recent accepted activate is at least `t_faw` cycles old.
- R7: An activate to a bank needs at least `t_rp` cycles since that bank was precharged, or `t_rp`+1 cycles if the last precharge that bank saw was a precharge-all.
- R8: A refused guarded command changes no bank state. The first refusal after reset sets `viol`, which stays high, and `viol_bank`/`viol_cmd` hold that refusal's bank and command code (activate=1, read=2, write=3, precharge=4, precharge-all=5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank number |
| all_banks | input | 1 | Selects precharge-all on a precharge |
| t_rc | input | 6 | Same-bank activate spacing, cycles |
| t_rrd | input | 6 | Any-bank activate spacing, cycles |
| t_ras | input | 6 | Activate-to-precharge minimum, cycles |
| t_rp | input | 6 | Precharge-to-activate minimum, cycles |
| t_faw | input | 6 | Four-activate window length, cycles |
| cmd_ok | output | 1 | Current command is legal this cycle |
| viol | output | 1 | Sticky: a guarded command was refused |
| viol_bank | output | 3 | Bank of the first refused command |
| viol_cmd | output | 3 | Code of the first refused command |

## Verification
The bench probes each limit one cycle before it expires and again on the cycle it expires. A design that compares with the wrong operator, or that starts its counters at zero instead of one, would accept a command one cycle early or refuse it one cycle late. The four-activate window is filled at the minimum spacing, so a history that keeps too few entries, or that ages them wrongly, would let a fifth activate through too early. After a precharge-all, the bench uses a `t_rc` that is already met so that only the extra precharge clock decides the result; a design that drops that clock would accept the activate one cycle too soon. The bench also issues a refused activate and then reads the same bank, which catches a design that updates bank state on a refusal.

// File: rtl/dag_pkg.sv
package dag_pkg;

    parameter int CNT_W  = 6;
    parameter int BANK_W = 3;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_PREA  = 3'd5,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef struct packed {
        logic [CNT_W-1:0] rc;
        logic [CNT_W-1:0] rrd;
        logic [CNT_W-1:0] ras;
        logic [CNT_W-1:0] rp;
        logic [CNT_W-1:0] faw;
    } tcfg_t;

    function automatic cmd_e dag_decode(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic all);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = all ? CMD_PREA : CMD_PRE;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
        return (x == {CNT_W{1'b1}}) ? x : x + 1'b1;
    endfunction

endpackage

// File: rtl/dag_bank.sv
module dag_bank
    import dag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tcfg_t cfg,
    input  logic  do_act,
    input  logic  do_pre,
    input  logic  pall_mark,
    output logic  is_open,
    output logic  act_ok,
    output logic  pre_ok
);
    logic [CNT_W-1:0] since_act;
    logic [CNT_W-1:0] since_pre;
    logic             pall_last;
    logic [CNT_W:0]   need_rp;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open   <= 1'b0;
            since_act <= '1;
            since_pre <= '1;
            pall_last <= 1'b0;
        end else begin
            since_act <= do_act ? {{(CNT_W-1){1'b0}}, 1'b1} : sat_inc(since_act);
            since_pre <= do_pre ? {{(CNT_W-1){1'b0}}, 1'b1} : sat_inc(since_pre);
            if (do_act) begin
                is_open <= 1'b1;
            end else if (do_pre) begin
                is_open   <= 1'b0;
                pall_last <= pall_mark;
            end
        end
    end

    always_comb begin
        need_rp = {1'b0, cfg.rp} + {{CNT_W{1'b0}}, pall_last};
        act_ok  = !is_open && (since_act >= cfg.rc) && ({1'b0, since_pre} >= need_rp);
        pre_ok  = !is_open || (since_act >= cfg.ras);
    end

    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (rst)
        do_act |-> !is_open);                                   // R3
    AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (rst)
        do_act |=> is_open);                                    // R3
    AST_SAME_BANK_RC: assert property (@(posedge clk) disable iff (rst)
        do_act |-> since_act >= cfg.rc);                        // R4
    AST_RAS_BEFORE_PRE: assert property (@(posedge clk) disable iff (rst)
        (do_pre && is_open) |-> since_act >= cfg.ras);          // R5

endmodule

// File: rtl/dag_act_hist.sv
module dag_act_hist
    import dag_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  tcfg_t cfg,
    input  logic  do_act,
    output logic  rrd_ok,
    output logic  faw_ok
);
    logic [CNT_W-1:0] age [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            age[0] <= '1;
        end else if (do_act) begin
            age[0] <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
            age[0] <= sat_inc(age[0]);
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                age[i] <= '1;
            end else if (do_act) begin
                age[i] <= sat_inc(age[i-1]);
            end else begin
                age[i] <= sat_inc(age[i]);
            end
        end
    end

    assign rrd_ok = age[0] >= cfg.rrd;
    assign faw_ok = age[DEPTH-1] >= cfg.faw;

    AST_RRD_SPACING: assert property (@(posedge clk) disable iff (rst)
        do_act |-> age[0] >= cfg.rrd);                          // R4
    AST_FAW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        do_act |-> age[DEPTH-1] >= cfg.faw);                    // R6

endmodule

// File: rtl/dram_act_guard.sv
module dram_act_guard
    import dag_pkg::*;
#(
    parameter int NB      = 8,
    parameter int WIN_ACT = 4,
    localparam int BW     = BANK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BW-1:0]    ba,
    input  logic             all_banks,
    input  logic [CNT_W-1:0] t_rc,
    input  logic [CNT_W-1:0] t_rrd,
    input  logic [CNT_W-1:0] t_ras,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_faw,
    output logic             cmd_ok,
    output logic             viol,
    output logic [BW-1:0]    viol_bank,
    output logic [2:0]       viol_cmd
);
    tcfg_t          cfg;
    cmd_e           op;
    logic           guarded;
    logic [NB-1:0]  open_vec, act_ok_vec, pre_ok_vec, do_act_vec, do_pre_vec;
    logic           pall_mark, rrd_ok, faw_ok, any_act;

    assign cfg = '{rc: t_rc, rrd: t_rrd, ras: t_ras, rp: t_rp, faw: t_faw};
    assign op  = dag_decode(cs_n, ras_n, cas_n, we_n, all_banks);

    always_comb begin
        guarded = 1'b1;
        case (op)
            CMD_ACT:  cmd_ok = act_ok_vec[ba] && rrd_ok && faw_ok;
            CMD_RD,
            CMD_WR:   cmd_ok = open_vec[ba];
            CMD_PRE:  cmd_ok = pre_ok_vec[ba];
            CMD_PREA: cmd_ok = &pre_ok_vec;
            default: begin
                cmd_ok  = 1'b1;
                guarded = 1'b0;
            end
        endcase
        pall_mark = cmd_ok && (op == CMD_PREA);
        any_act   = cmd_ok && (op == CMD_ACT);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign do_act_vec[b] = any_act && (ba == b[BW-1:0]);
        assign do_pre_vec[b] = cmd_ok && ((op == CMD_PRE && ba == b[BW-1:0]) || op == CMD_PREA);

        dag_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg),
            .do_act   (do_act_vec[b]),
            .do_pre   (do_pre_vec[b]),
            .pall_mark(pall_mark),
            .is_open  (open_vec[b]),
            .act_ok   (act_ok_vec[b]),
            .pre_ok   (pre_ok_vec[b])
        );
    end

    dag_act_hist #(.DEPTH(WIN_ACT)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .do_act(any_act),
        .rrd_ok(rrd_ok),
        .faw_ok(faw_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= 1'b0;
            viol_bank <= '0;
            viol_cmd  <= 3'd0;
        end else if (guarded && !cmd_ok && !viol) begin
            viol      <= 1'b1;
            viol_bank <= (op == CMD_PREA) ? '0 : ba;
            viol_cmd  <= op;
        end
    end

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);                                         // R8
    AST_REFUSE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (guarded && !cmd_ok) |=> $stable(open_vec));            // R8
    AST_RD_WR_OPEN: assert property (@(posedge clk) disable iff (rst)
        ((op == CMD_RD || op == CMD_WR) && cmd_ok) |=> open_vec[$past(ba)]); // R3

endmodule

// File: tb/dram_act_guard_test.sv
module dram_act_guard_test;
    import dag_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, all_banks = 1'b0;
    logic [2:0] ba = '0;
    logic [5:0] t_rc = 6'd10, t_rrd = 6'd2, t_ras = 6'd5, t_rp = 6'd3, t_faw = 6'd10;
    logic cmd_ok, viol;
    logic [2:0] viol_bank, viol_cmd;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dram_act_guard uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .all_banks(all_banks), .t_rc(t_rc), .t_rrd(t_rrd), .t_ras(t_ras),
        .t_rp(t_rp), .t_faw(t_faw), .cmd_ok(cmd_ok), .viol(viol),
        .viol_bank(viol_bank), .viol_cmd(viol_cmd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input cmd_e op, input int b);
        ba = b[2:0];
        all_banks = 1'b0;
        cs_n = 1'b0;
        case (op)
            CMD_ACT:  {ras_n, cas_n, we_n} = 3'b011;
            CMD_RD:   {ras_n, cas_n, we_n} = 3'b101;
            CMD_WR:   {ras_n, cas_n, we_n} = 3'b100;
            CMD_PRE:  {ras_n, cas_n, we_n} = 3'b010;
            CMD_PREA: begin {ras_n, cas_n, we_n} = 3'b010; all_banks = 1'b1; end
            CMD_OTHER: {ras_n, cas_n, we_n} = 3'b001;
            default:  begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
        endcase
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive(CMD_NOP, 0);
        end
    endtask

    // one cycle: look at cmd_ok, then withdraw the command before the edge
    task automatic probe(input cmd_e op, input int b, input int exp, input string tag);
        @(negedge clk);
        drive(op, b);
        #2;
        chk(tag, cmd_ok, exp);
        drive(CMD_NOP, 0);
    endtask

    // one cycle: present the command through the edge
    task automatic issue(input cmd_e op, input int b, input int exp, input string tag);
        @(negedge clk);
        drive(op, b);
        #2;
        chk(tag, cmd_ok, exp);
        @(posedge clk);
        #1;
        drive(CMD_NOP, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(CMD_NOP, 0);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic test_reset_decode();
        do_reset();
        chk("R2 viol after reset", viol, 0);
        probe(CMD_ACT, 0, 1, "R2 act right after reset");
        probe(CMD_RD, 0, 0, "R3 read closed bank");
        probe(CMD_NOP, 0, 1, "R1 deselect unguarded");
        probe(CMD_OTHER, 0, 1, "R1 other pattern unguarded");
        probe(CMD_PRE, 4, 1, "R5 precharge closed bank");
        chk("R1 no violation from unguarded", viol, 0);
    endtask

    task automatic test_bank_cycle();
        do_reset();
        issue(CMD_ACT, 2, 1, "R3 act bank2");
        probe(CMD_ACT, 3, 0, "R4 rrd at 1");
        probe(CMD_WR, 2, 1, "R1 write open bank");
        probe(CMD_PRE, 2, 0, "R5 ras at 3");
        probe(CMD_ACT, 2, 0, "R3 act open bank");
        issue(CMD_PRE, 2, 1, "R5 ras met at 5");
        probe(CMD_RD, 2, 0, "R3 read after precharge");
        probe(CMD_ACT, 2, 0, "R7 rp at 2");
        probe(CMD_ACT, 2, 0, "R4 rc at 8");
        probe(CMD_ACT, 2, 0, "R4 rc at 9");
        probe(CMD_ACT, 2, 1, "R4 rc met at 10");
    endtask

    task automatic test_faw();
        do_reset();
        issue(CMD_ACT, 0, 1, "R6 act 1");
        idle(1);
        issue(CMD_ACT, 1, 1, "R6 act 2");
        idle(1);
        issue(CMD_ACT, 2, 1, "R6 act 3");
        idle(1);
        issue(CMD_ACT, 3, 1, "R6 act 4");
        idle(1);
        probe(CMD_ACT, 4, 0, "R6 fifth at 8");
        probe(CMD_ACT, 4, 0, "R6 fifth at 9");
        issue(CMD_ACT, 4, 1, "R6 fifth at 10");
        idle(1);
        probe(CMD_ACT, 5, 1, "R6 sixth at 12");
    endtask

    task automatic test_prea();
        do_reset();
        issue(CMD_ACT, 0, 1, "R3 act bank0");
        idle(1);
        issue(CMD_ACT, 1, 1, "R3 act bank1");
        idle(3);
        probe(CMD_PREA, 0, 0, "R5 prea bank1 ras unmet");
        issue(CMD_PREA, 0, 1, "R5 prea all ras met");
        idle(2);
        probe(CMD_ACT, 0, 0, "R7 act at rp after prea");
        probe(CMD_ACT, 0, 1, "R7 act at rp+1 after prea");
    endtask

    task automatic test_violation();
        do_reset();
        issue(CMD_ACT, 5, 1, "R3 act bank5");
        issue(CMD_ACT, 3, 0, "R4 rrd refuse");
        chk("R8 viol set", viol, 1);
        chk("R8 viol bank", viol_bank, 3);
        chk("R8 viol cmd act=1", viol_cmd, 1);
        probe(CMD_RD, 3, 0, "R8 refused act left bank closed");
        issue(CMD_WR, 6, 0, "R3 write closed bank");
        chk("R8 viol still set", viol, 1);
        chk("R8 first bank kept", viol_bank, 3);
        chk("R8 first cmd kept", viol_cmd, 1);
        probe(CMD_RD, 5, 1, "R3 bank5 still open");
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset_decode();
        test_bank_cycle();
        test_faw();
        test_prea();
        test_violation();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule